// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the digital front end of a 16-bit serial-input converter. A host sends a word over three wires: an active-low chip select, a serial clock and a data line. The block samples those pins into its own system clock domain, shifts the word in most significant bit first and holds it in an input register. It then copies the word into a separate output latch, which drives the parallel code to the converter core.

The copy can happen at one of two moments, set by a static mode pin. In three-wire mode the latch loads when chip select returns high. In four-wire mode, chip select returning high only stages the word. A later falling edge on a separate active-low load strobe moves the staged word into the latch, so several converters can be updated at the same moment. A frame that does not contain at least 16 clock edges is discarded and raises an error flag. A reset clears the latch to code 0x0000, which is the lowest output of the converter.

The output code is a level with no handshake. It holds its value until the next accepted load, so the core can never apply back-pressure and no word is ever waiting at the output side.

Top module: `serial_dac_front`

## Requirements
- R1: While reset is asserted and just after it is released, `dac_code` is 0x0000 and `frame_err` is 0.
- R2: While `cs_n` is low, each rising edge of `sclk` samples `din` into the input register. The first bit sampled is bit 15 of the word and the 16th bit sampled is bit 0.
- R3: Edges on `sclk` while `cs_n` is high shift nothing and do not change the outputs.
- R4: Within one frame, clock edges after the 16th are ignored. The first 16 bits are kept.
- R5: When `cs_n` rises after fewer than 16 clock edges, the latch keeps its value and `frame_err` becomes 1. With no strobe edge in the same cycle, no load takes place.
- R6: When `cs_n` rises after a complete frame, `frame_err` is cleared to 0.
- R7: With `four_wire` = 1, a complete frame does not change `dac_code` when `cs_n` rises. The next falling edge of `ldac_n` loads that word.
- R8: With `four_wire` = 1, a falling edge of `ldac_n` when no word is staged leaves `dac_code` unchanged. This covers a second strobe, and a strobe after an incomplete frame.
- R9: With `four_wire` = 0, the latch loads the new word when `cs_n` rises, and `ldac_n` has no effect.
- R10: An accepted load appears on `dac_code` within 6 system clock cycles of the pin edge that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, acting as the power-on clear |
| four_wire | input | 1 | Mode select, held static: 1 means the strobe loads the latch, 0 means chip select rising loads it |
| cs_n | input | 1 | Active-low chip select, asynchronous to `clk` |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| din | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load strobe, acting on its falling edge |
| dac_code | output | 16 | Parallel output latch |
| frame_err | output | 1 | 1 when the most recent frame was incomplete |

## Verification
The assertions assume the following about the inputs:
- every pin level lasts for at least three system clocks;
- `din` is steady across the synchronized rising edge of `sclk`;
- chip select and the serial clock never change in the same synchronized cycle;
- the strobe never falls in the same cycle that chip select rises;
- `four_wire` changes only while the bus is idle.

The stimulus holds each pin phase for three clocks and changes the mode only between frames. It issues the strobe only after chip select has settled high. Random frame lengths from 0 to 20 edges then exercise the short, exact and over-long cases within these rules.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int SYNC_STAGES = 2;
  localparam logic [WORD_W-1:0] CLEAR_CODE = '0;
endpackage

// File: rtl/dacfe_pin_sync.sv
module dacfe_pin_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= {STAGES{IDLE[g]}};
        prev  <= IDLE[g];
      end else begin
        chain <= {chain[STAGES-2:0], pin[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~prev;
    assign fall[g] = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/dacfe_shift_rx.sv
module dacfe_shift_rx #(
  parameter int W = 16,
  parameter int CW = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_lvl,
  input  logic         cs_fall,
  input  logic         cs_rise,
  input  logic         sclk_rise,
  input  logic         din_lvl,
  output logic [W-1:0] word,
  output logic         frame_ok,
  output logic         frame_bad
);
  localparam logic [CW-1:0] FULL = CW'(W);
  logic [CW-1:0] cnt;
  logic          take;

  assign take = sclk_rise && !cs_lvl && (cnt < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      word <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (take) begin
      cnt  <= cnt + 1'b1;
      word <= {word[W-2:0], din_lvl};
    end
  end

  assign frame_ok  = cs_rise && (cnt == FULL);
  assign frame_bad = cs_rise && (cnt != FULL);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R4
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> $stable(word) && $stable(cnt)); // R3
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL) && !cs_fall |=> $stable(word)); // R4
  AST_OK_BAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok, frame_bad})); // R5
endmodule

// File: rtl/dacfe_latch_ctrl.sv
module dacfe_latch_ctrl #(
  parameter int W = 16,
  parameter logic [W-1:0] CLEAR = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         four_wire,
  input  logic         frame_ok,
  input  logic         frame_bad,
  input  logic [W-1:0] word,
  input  logic         ldac_fall,
  output logic [W-1:0] code,
  output logic         frame_err
);
  logic [W-1:0] staged;
  logic         pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code      <= CLEAR;
      staged    <= CLEAR;
      pending   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (frame_ok) begin
        frame_err <= 1'b0;
        if (four_wire) begin
          staged  <= word;
          pending <= 1'b1;
        end else begin
          code <= word;
        end
      end else if (frame_bad) begin
        frame_err <= 1'b1;
      end
      if (four_wire && ldac_fall && pending && !frame_ok) begin
        code    <= staged;
        pending <= 1'b0;
      end
    end
  end

  AST_BAD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad && !ldac_fall |=> $stable(code) && frame_err); // R5
  AST_GOOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_err); // R6
  AST_FOUR_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    four_wire && frame_ok && !ldac_fall |=> $stable(code) && pending); // R7
  AST_PEND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    four_wire && ldac_fall && pending && !frame_ok |=> !pending); // R7
  AST_NOPEND_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    four_wire && ldac_fall && !pending && !frame_ok |=> $stable(code)); // R8
  AST_THREE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !four_wire && !frame_ok |=> $stable(code)); // R9
endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              four_wire,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              ldac_n,
  output logic [WORD_W-1:0] dac_code,
  output logic              frame_err
);
  localparam int PINS = 4;
  localparam int P_CS = 0;
  localparam int P_SCK = 1;
  localparam int P_DIN = 2;
  localparam int P_LD = 3;
  localparam logic [PINS-1:0] IDLE_LVL = 4'b1001;

  logic [PINS-1:0] pin_lvl, pin_rise, pin_fall;
  logic [WORD_W-1:0] rx_word;
  logic rx_ok, rx_bad;

  dacfe_pin_sync #(.N(PINS), .STAGES(SYNC_STAGES), .IDLE(IDLE_LVL)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .pin ({ldac_n, din, sclk, cs_n}),
    .lvl (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  dacfe_shift_rx #(.W(WORD_W), .CW(CNT_W)) u_rx (
    .clk (clk),
    .rst_n (rst_n),
    .cs_lvl (pin_lvl[P_CS]),
    .cs_fall (pin_fall[P_CS]),
    .cs_rise (pin_rise[P_CS]),
    .sclk_rise (pin_rise[P_SCK]),
    .din_lvl (pin_lvl[P_DIN]),
    .word (rx_word),
    .frame_ok (rx_ok),
    .frame_bad (rx_bad)
  );

  dacfe_latch_ctrl #(.W(WORD_W), .CLEAR(CLEAR_CODE)) u_latch (
    .clk (clk),
    .rst_n (rst_n),
    .four_wire (four_wire),
    .frame_ok (rx_ok),
    .frame_bad (rx_bad),
    .word (rx_word),
    .ldac_fall (pin_fall[P_LD]),
    .code (dac_code),
    .frame_err (frame_err)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> dac_code == CLEAR_CODE && !frame_err); // R1
  AST_THREE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !four_wire && rx_ok |=> dac_code == $past(rx_word)); // R9
endmodule

// File: tb/serial_dac_front_bench.sv
module serial_dac_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic four_wire = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic ldac_n = 1'b1;
  logic [15:0] dac_code;
  logic frame_err;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] m_code = 16'h0000;
  logic [15:0] m_staged = 16'h0000;
  bit m_pend = 0;
  bit m_err = 0;

  always #10 clk = ~clk;

  serial_dac_front u_serial_dac_front (
    .clk(clk), .rst_n(rst_n), .four_wire(four_wire), .cs_n(cs_n),
    .sclk(sclk), .din(din), .ldac_n(ldac_n),
    .dac_code(dac_code), .frame_err(frame_err)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit frame_complete(input int nbits);
    return nbits >= 16;
  endfunction

  task automatic model_frame(input logic [15:0] w, input int nbits);
    if (frame_complete(nbits)) begin
      m_err = 0;
      if (four_wire) begin m_staged = w; m_pend = 1; end
      else m_code = w;
    end else begin
      m_err = 1;
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits);
    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 16) ? w[15-i] : 1'($urandom);
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
      sclk = 1'b0;
    end
    wait_clk(3);
    cs_n = 1'b1;
    wait_clk(6);
    model_frame(w, nbits);
  endtask

  task automatic strobe();
    ldac_n = 1'b0;
    wait_clk(6);
    if (four_wire && m_pend) begin m_code = m_staged; m_pend = 0; end
    ldac_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic check_state(input string req);
    check(req, {16'h0, dac_code}, {16'h0, m_code});
    check(req, {31'h0, frame_err}, {31'h0, m_err});
  endtask

  initial begin
    process::self().srandom(32'h5EED_0141);
    wait_clk(3);
    check("R1", {16'h0, dac_code}, 32'h0);
    check("R1", {31'h0, frame_err}, 32'h0);
    rst_n = 1'b1;
    wait_clk(3);
    check("R1", {16'h0, dac_code}, 32'h0);

    send_frame(16'hA5C3, 16); check_state("R2");
    send_frame(16'h0001, 16); check_state("R2");
    // R10: load visible 6 clocks after chip select release
    cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 16; i++) begin
      din = 1'b1; wait_clk(3); sclk = 1'b1; wait_clk(3); sclk = 1'b0;
    end
    wait_clk(3); cs_n = 1'b1; wait_clk(6);
    model_frame(16'hFFFF, 16);
    check("R10", {16'h0, dac_code}, 32'hFFFF);

    for (int i = 0; i < 5; i++) begin
      din = ~din; wait_clk(3); sclk = 1'b1; wait_clk(3); sclk = 1'b0;
    end
    wait_clk(6);
    check("R3", {16'h0, dac_code}, 32'hFFFF);
    send_frame(16'h1234, 16); check_state("R3");

    send_frame(16'h8E71, 20); check_state("R4");
    send_frame(16'h4444, 10); check_state("R5");
    check("R5", {31'h0, frame_err}, 32'h1);
    send_frame(16'h0F0F, 0); check_state("R5");
    send_frame(16'h3C3C, 16); check_state("R6");
    check("R6", {31'h0, frame_err}, 32'h0);
    strobe(); check_state("R9");

    four_wire = 1'b1; wait_clk(2);
    send_frame(16'hBEEF, 16);
    check("R7", {16'h0, dac_code}, 32'h3C3C);
    strobe(); check("R7", {16'h0, dac_code}, 32'hBEEF);
    strobe(); check("R8", {16'h0, dac_code}, 32'hBEEF);
    send_frame(16'h7777, 9); check_state("R8");
    strobe(); check("R8", {16'h0, dac_code}, 32'hBEEF);

    for (int k = 0; k < 70; k++) begin
      logic [15:0] w;
      int nb;
      w = 16'($urandom);
      nb = ($urandom % 4 == 0) ? int'($urandom % 21) : 16;
      if ($urandom % 8 == 0) begin four_wire = ~four_wire; wait_clk(2); end
      send_frame(w, nb);
      check_state(four_wire ? "R7" : "R2");
      if ($urandom % 2 == 0) begin strobe(); check_state(four_wire ? "R8" : "R9"); end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule